// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block moves board setup words between a 64-word by 16-bit serial EEPROM and a set of on-chip registers. After hardware reset it fetches a configuration word, a base word and three station-address words, without any help from software. Three strap pins choose an EEPROM slot, so several identical boards can sit in one system with different setups. One strap code means "use the built-in defaults", and then only the station address is fetched.

Software drives the block through a small control register. A reload bit repeats the full fetch. A store bit writes the configuration and base registers back to their strap-selected slot. A select bit turns the same engine into a general purpose port: one word at a pointer-given address is read into, or written from, a general purpose register. The EEPROM is reached over a four-wire serial port (chip select, serial clock, data to the part, data from the part). The serial clock is derived from the system clock.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: After reset the block starts a load without any host action. The configuration register receives EEPROM word strap*4 and the base register receives word strap*4+1.
- R2: Every load reads words 0x20, 0x21 and 0x22 into station_q bits [15:0], [31:16] and [47:32] respectively, whatever the strap value is.
- R3: With strap value 7, a load issues exactly three read frames (the station words only), and the configuration and base registers take DEF_CFG and DEF_BASE.
- R4: Control register encoding (reg_sel 0): bit 0 requests a store, bit 1 requests a reload, bit 2 is the select bit. ctl_q returns {select, reload, store}. Writing only the select bit starts nothing. The reload bit reads 1 during the load that follows reset.
- R5: With select 0, a store sends a write-enable frame, then writes the configuration register to word strap*4 and the base register to word strap*4+1.
- R6: With select 1, a reload reads the word at address ptr[5:0] into gp_q and leaves cfg_q, base_q and station_q unchanged.
- R7: With select 1, a store writes gp_q to the word at address ptr[5:0], after a write-enable frame.
- R8: Every frame starts with a 1 and then a 2-bit opcode, all bits sent MSB first. A read is 1,1,0, a 6-bit address, then 16 data bits shifted in. A write-enable is 1,0,0,1,1,0,0,0,0. A write is 1,0,1, a 6-bit address, then 16 data bits shifted out.
- R9: After each write frame, chip select goes low, then high again. The block then waits until ee_do is high before it starts another frame or finishes.
- R10: One serial clock period lasts 2*CLK_DIV system clocks, and ee_sk is high only while ee_cs is high.
- R11: busy is high while any sequence runs. The reload and store bits clear themselves when their sequence ends. Host register writes made while busy have no effect.
- R12: A control write with both reload and store set runs the reload only, and no write frame is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 3 | Slot-select strap pins |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 2 | 0 control, 1 configuration, 2 base, 3 general purpose |
| reg_wdata | input | 16 | Host write data |
| ptr | input | 6 | Word address for general purpose mode |
| ctl_q | output | 3 | {select, reload, store} |
| busy | output | 1 | A sequence is running |
| cfg_q | output | 16 | Configuration register |
| base_q | output | 16 | Base register |
| gp_q | output | 16 | General purpose register |
| station_q | output | 48 | Station address, word 0x20 in the low bits |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready flag from the EEPROM |

## Verification
The hardest case to reach is a host write that arrives in the middle of a sequence. Such a write must be dropped, yet it must not disturb the serial traffic. The bench starts a general purpose read and then, within two cycles, writes a new configuration value and a store request. After the engine finishes, it checks that the configuration register still holds the value loaded earlier and that the EEPROM model has seen no write. The ready wait after a write is checked by an EEPROM model that stays busy for a fixed time and counts as a protocol error any frame that begins while it is still busy.

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
  parameter int          CLK_DIV  = 4,
  parameter logic [15:0] DEF_CFG  = 16'h1C00,
  parameter logic [15:0] DEF_BASE = 16'h0300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  strap,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [15:0] reg_wdata,
  input  logic [5:0]  ptr,
  output logic [2:0]  ctl_q,
  output logic        busy,
  output logic [15:0] cfg_q,
  output logic [15:0] base_q,
  output logic [15:0] gp_q,
  output logic [47:0] station_q,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int DW    = 16;
  localparam int AW    = 6;
  localparam int HDR   = 3 + AW;
  localparam int FRAME = HDR + DW;
  localparam int BW    = $clog2(FRAME);
  localparam int CW    = $clog2(CLK_DIV + 1);
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_EN = 2'b00;

  typedef enum logic [1:0] {J_LOAD, J_STORE, J_GPRD, J_GPWR} job_t;
  typedef enum logic [2:0] {S_IDLE, S_START, S_SHIFT, S_END, S_RDY} state_t;

  state_t          state;
  job_t            job, go_job;
  logic [2:0]      step, strap_q;
  logic [AW-1:0]   ptr_q, addr;
  logic [CW-1:0]   div_cnt;
  logic [BW-1:0]   bcnt, last_bit;
  logic [FRAME-1:0] tx;
  logic [DW-1:0]   rx, wdat;
  logic [1:0]      op;
  logic            boot, sel_b, rld_b, sto_b, last, go, tick, adv, ctl_wr;

  assign busy     = boot || (state != S_IDLE);
  assign ctl_q    = {sel_b, rld_b, sto_b};
  assign tick     = (div_cnt == CW'(CLK_DIV - 1));
  assign ee_di    = (state == S_SHIFT) && tx[FRAME-1];
  assign ctl_wr   = reg_wr && !busy && (reg_sel == 2'd0);
  assign go       = boot || (ctl_wr && (reg_wdata[1] || reg_wdata[0]));
  assign last_bit = (op == OP_EN) ? BW'(HDR - 1) : BW'(FRAME - 1);
  assign adv      = tick && (((state == S_END) && (op != OP_WR)) ||
                             ((state == S_RDY) && ee_cs && ee_do));

  always_comb begin
    if (boot || reg_wdata[1]) go_job = (boot || !reg_wdata[2]) ? J_LOAD : J_GPRD;
    else                      go_job = reg_wdata[2] ? J_GPWR : J_STORE;
  end

  always_comb begin
    op   = OP_RD;
    addr = '0;
    wdat = '0;
    last = 1'b0;
    case (job)
      J_LOAD: begin
        if (step == 3'd0)      addr = {1'b0, strap_q, 2'b00};
        else if (step == 3'd1) addr = {1'b0, strap_q, 2'b01};
        else                   addr = 6'h1E + {3'b000, step};
        last = (step == 3'd4);
      end
      J_STORE: begin
        op   = (step == 3'd0) ? OP_EN : OP_WR;
        addr = (step == 3'd0) ? 6'b110000 : {1'b0, strap_q, 1'b0, step == 3'd2};
        wdat = (step == 3'd2) ? base_q : cfg_q;
        last = (step == 3'd2);
      end
      J_GPRD: begin
        addr = ptr_q;
        last = 1'b1;
      end
      default: begin
        op   = (step == 3'd0) ? OP_EN : OP_WR;
        addr = (step == 3'd0) ? 6'b110000 : ptr_q;
        wdat = gp_q;
        last = (step == 3'd1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  job <= J_LOAD;  step <= '0;  strap_q <= '0;  ptr_q <= '0;
      boot <= 1'b1;  sel_b <= 1'b0;  rld_b <= 1'b1;  sto_b <= 1'b0;
      cfg_q <= DEF_CFG;  base_q <= DEF_BASE;  gp_q <= '0;  station_q <= '0;
      div_cnt <= '0;  bcnt <= '0;  tx <= '0;  rx <= '0;
      ee_cs <= 1'b0;  ee_sk <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (reg_wr && !busy) begin
        case (reg_sel)
          2'd0: begin
            sel_b <= reg_wdata[2];
            rld_b <= reg_wdata[1];
            sto_b <= reg_wdata[0] && !reg_wdata[1];
          end
          2'd1: cfg_q  <= reg_wdata;
          2'd2: base_q <= reg_wdata;
          default: gp_q <= reg_wdata;
        endcase
      end
      if (go && state == S_IDLE) begin
        boot    <= 1'b0;
        job     <= go_job;
        strap_q <= strap;
        ptr_q   <= ptr;
        state   <= S_START;
        step    <= (go_job == J_LOAD && strap == 3'd7) ? 3'd2 : 3'd0;
        if (go_job == J_LOAD && strap == 3'd7) begin
          cfg_q  <= DEF_CFG;
          base_q <= DEF_BASE;
        end
      end
      if (tick) begin
        case (state)
          S_START: begin
            ee_cs <= 1'b1;
            ee_sk <= 1'b0;
            tx    <= {1'b1, op, addr, wdat};
            bcnt  <= '0;
            state <= S_SHIFT;
          end
          S_SHIFT: begin
            if (!ee_sk) ee_sk <= 1'b1;
            else begin
              ee_sk <= 1'b0;
              rx    <= {rx[DW-2:0], ee_do};
              tx    <= {tx[FRAME-2:0], 1'b0};
              if (bcnt == last_bit) state <= S_END;
              else bcnt <= bcnt + 1'b1;
            end
          end
          S_END: begin
            ee_cs <= 1'b0;
            if (op == OP_WR) state <= S_RDY;
            if (op == OP_RD) begin
              if (job == J_GPRD) gp_q <= rx;
              else case (step)
                3'd0: cfg_q <= rx;
                3'd1: base_q <= rx;
                3'd2: station_q[15:0]  <= rx;
                3'd3: station_q[31:16] <= rx;
                default: station_q[47:32] <= rx;
              endcase
            end
          end
          S_RDY: begin
            if (!ee_cs) ee_cs <= 1'b1;
            else if (ee_do) ee_cs <= 1'b0;
          end
          default: ;
        endcase
      end
      if (adv) begin
        if (last) begin
          state <= S_IDLE;
          rld_b <= 1'b0;
          sto_b <= 1'b0;
        end else begin
          step  <= step + 3'd1;
          state <= S_START;
        end
      end
    end
  end

  // R10
  sk_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs);

  // R10
  sk_rate_chk: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(ee_sk));

  // R11
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !ee_cs);

  // R11
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ctl_q[1:0] == 2'b00));

  // R6
  gp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && job == J_GPRD) |=> ($stable(cfg_q) && $stable(base_q) && $stable(station_q)));

  // R9
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDY && ee_cs && !ee_do) |=> (state == S_RDY));
endmodule

// File: tb/tb_eeprom_cfg_loader.sv
`timescale 1ns/1ps
module tb_eeprom_cfg_loader;
  localparam int          CLK_DIV  = 4;
  localparam logic [15:0] DEF_CFG  = 16'h1C00;
  localparam logic [15:0] DEF_BASE = 16'h0300;
  localparam logic [2:0]  VSTRAP [5] = '{3'd0, 3'd5, 3'd7, 3'd3, 3'd6};
  localparam int          VREADS [5] = '{5, 5, 3, 5, 5};

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] strap = 3'd2;
  logic [1:0] reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [5:0] ptr = '0;
  logic [2:0] ctl_q;
  logic busy, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] cfg_q, base_q, gp_q;
  logic [47:0] station_q;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  eeprom_cfg_loader #(.CLK_DIV(CLK_DIV), .DEF_CFG(DEF_CFG), .DEF_BASE(DEF_BASE)) dut (
    .clk(clk), .rst_n(rst_n), .strap(strap), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ptr(ptr), .ctl_q(ctl_q), .busy(busy), .cfg_q(cfg_q),
    .base_q(base_q), .gp_q(gp_q), .station_q(station_q), .ee_cs(ee_cs),
    .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  logic [15:0] mem [64];
  int bitn = 0, nreads = 0, nwrites = 0, proto_err = 0;
  longint cyc = 0, ready_at = 0;
  logic [8:0] hdr = '0, last_rd_hdr = '0, last_wr_hdr = '0, en_hdr = '0;
  logic [15:0] din = '0;
  logic do_r = 1'b0;
  bit ewen = 0;

  initial for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0923 + 16'h1357);

  always @(posedge clk) cyc <= cyc + 1;

  assign ee_do = (ee_cs && bitn == 0) ? (cyc >= ready_at) : do_r;

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      if (bitn == 25 && hdr[8:6] == 3'b110) begin nreads++; last_rd_hdr = hdr; end
      else if (bitn == 9 && hdr[8:6] == 3'b100 && hdr[5:4] == 2'b11) begin ewen = 1; en_hdr = hdr; end
      else if (bitn == 25 && hdr[8:6] == 3'b101) begin
        if (ewen) begin
          mem[hdr[5:0]] = din; nwrites++; last_wr_hdr = hdr; ready_at = cyc + 40;
        end else proto_err++;
      end
      else if (bitn != 0) proto_err++;
      bitn = 0;
    end else begin
      if (bitn == 0 && (ee_di !== 1'b1 || cyc < ready_at)) proto_err++;
      if (bitn < 9) hdr = {hdr[7:0], ee_di};
      else begin
        din = {din[14:0], ee_di};
        if (hdr[8:6] == 3'b110) do_r = mem[hdr[5:0]][24 - bitn];
      end
      bitn++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle;
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    int r0, w0;
    realtime t1, t2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 busy after reset", busy, 1);
    chk("R4 reload bit during boot load", ctl_q, 3'b010);
    wait_idle();
    chk("R1 boot cfg", cfg_q, mem[8]);
    chk("R1 boot base", base_q, mem[9]);
    chk("R2 boot station", station_q, {mem[34], mem[33], mem[32]});
    chk("R11 reload self-clear", ctl_q, 3'b000);

    for (int v = 0; v < 5; v++) begin
      strap = VSTRAP[v];
      host_wr(2'd1, 16'hFFFF);
      host_wr(2'd2, 16'hFFFF);
      r0 = nreads;
      host_wr(2'd0, 16'h0002);
      wait_idle();
      chk("R1 R3 cfg per strap", cfg_q, (VSTRAP[v] == 3'd7) ? DEF_CFG : mem[VSTRAP[v] * 4]);
      chk("R1 R3 base per strap", base_q, (VSTRAP[v] == 3'd7) ? DEF_BASE : mem[VSTRAP[v] * 4 + 1]);
      chk("R2 station per strap", station_q, {mem[34], mem[33], mem[32]});
      chk("R3 read frame count", nreads - r0, VREADS[v]);
    end

    host_wr(2'd0, 16'h0002);
    @(posedge ee_sk); t1 = $realtime;
    @(posedge ee_sk); t2 = $realtime;
    wait_idle();
    chk("R10 sk period ns", int'(t2 - t1), 2 * CLK_DIV * 5);
    chk("R8 read header", last_rd_hdr, 9'b1_10_100010);

    strap = 3'd1;
    host_wr(2'd1, 16'hC0DE);
    host_wr(2'd2, 16'hBA5E);
    w0 = nwrites;
    host_wr(2'd0, 16'h0001);
    chk("R11 busy during store", busy, 1);
    wait_idle();
    chk("R5 cfg written", mem[4], 16'hC0DE);
    chk("R5 base written", mem[5], 16'hBA5E);
    chk("R5 write count", nwrites - w0, 2);
    chk("R8 enable header", en_hdr, 9'b1_00_110000);
    chk("R8 write header", last_wr_hdr, 9'b1_01_000101);
    chk("R9 no frame while part busy", proto_err, 0);
    chk("R9 finished after ready", cyc >= ready_at, 1);
    chk("R11 store self-clear", ctl_q, 3'b000);

    host_wr(2'd0, 16'h0004);
    chk("R4 select only starts nothing", {busy, ctl_q}, 4'b0100);
    ptr = 6'h2B;
    host_wr(2'd0, 16'h0006);
    host_wr(2'd1, 16'hDEAD);
    wait_idle();
    chk("R6 gp read", gp_q, mem[6'h2B]);
    chk("R6 R11 cfg kept", cfg_q, 16'hC0DE);
    chk("R6 station kept", station_q, {mem[34], mem[33], mem[32]});

    host_wr(2'd3, 16'h7E57);
    ptr = 6'h11;
    w0 = nwrites;
    host_wr(2'd0, 16'h0005);
    wait_idle();
    chk("R7 gp write", mem[6'h11], 16'h7E57);
    chk("R7 write count", nwrites - w0, 1);
    chk("R7 cfg kept", cfg_q, 16'hC0DE);

    ptr = 6'h30;
    w0 = nwrites;
    host_wr(2'd0, 16'h0006);
    host_wr(2'd0, 16'h0001);
    wait_idle();
    chk("R11 store during busy ignored", nwrites - w0, 0);
    chk("R11 ctl after ignored request", ctl_q, 3'b100);

    host_wr(2'd0, 16'h0000);
    host_wr(2'd1, 16'h1111);
    w0 = nwrites;
    host_wr(2'd0, 16'h0003);
    chk("R12 only reload bit set", ctl_q, 3'b010);
    wait_idle();
    chk("R12 no write frame", nwrites - w0, 0);
    chk("R12 reload result", cfg_q, mem[4]);
    chk("R9 protocol clean at end", proto_err, 0);
    finish_up();
  end
endmodule